// File: doc/BRIEF.md
# Closed Caption Line Encoder

This block generates the digital luma samples that carry caption text and extended data on two vertical-blanking lines of a 27 MHz video line stream. Each of the two services owns a pair of character registers that a host fills through a small write port. When a designated line begins and its service is switched on, the block waits a fixed delay after the horizontal reference. It then sends seven run-in cycles, a start pattern and the two characters, one level code per clock, and raises a valid flag so a downstream mixer can replace the active luma for that span.

The host refreshes a service by writing its first character and then its second one. The second write marks the pair as new. A pair that was not refreshed since the last send is replaced by a pair of null characters. A ready flag per service tells the host when it may write the next pair. Level codes, delay and bit rate are parameters.

Top module: `cc_line_encoder`

## Requirements
- R1: Write addresses are 0 (caption first character), 1 (caption second character), 2 (extended first character) and 3 (extended second character). Only a write to the second character (address 1 or 3) marks that service's pair as new. A first-character write alone does not.
- R2: On its designated line a service sends its stored pair if the pair is new, otherwise the null pair 8'h80, 8'h80. Characters go out exactly as written, with bit 7 taken as the host's parity bit and no parity computed. Sending a pair consumes its new mark.
- R3: A transmission is armed only by an hstart_i pulse while the encoder is idle. With std625_i=0 the caption line is 21 and the extended line is 284. With std625_i=1 they are 21 and 334. Any other line sends nothing.
- R4: luma_vld_o rises exactly START_DLY (default 284, about 10.5 us) clocks after the clock edge that samples hstart_i.
- R5: The half-bit sequence is as follows. First come seven run-in cycles, each a high half then a low half. Then come two 0 bits and one 1 start bit. Then come the first character, bit 0 first and bit 7 last, followed by the second character in the same order.
- R6: Half-bit timing uses a 16-bit phase accumulator that starts at 0 and adds HALF_INC (default 2444) each clock. Each overflow advances one half bit. The transmission ends with the 52nd overflow, so it lasts ceil(52*65536/HALF_INC) clocks.
- R7: When a service's enable input is low, its designated line produces no output and its pending pair stays new. The pair is sent on the first enabled occurrence of that line.
- R8: While luma_vld_o is high, a 1 symbol gives HIGH_LVL (default 560) and a 0 symbol gives BLANK_LVL (default 240). While it is low, luma_o is 0.
- R9: rdy_o[0] covers the caption service and rdy_o[1] the extended service. A flag drops on the clock after its second-character write. It stays low until that service's line has been fully sent with no newer second-character write pending. After reset both flags are 1 and luma_vld_o is 0.
- R10: A second-character write during a transmission does not change the waveform in progress. The new pair is sent on the next designated line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hstart_i | input | 1 | One-clock horizontal reference pulse at line start |
| line_num_i | input | 10 | Number of the line that hstart_i opens |
| std625_i | input | 1 | 1 selects the 625-line line pair |
| en_cap_i | input | 1 | Caption service enable |
| en_ext_i | input | 1 | Extended-data service enable |
| wr_en_i | input | 1 | Character register write strobe |
| wr_addr_i | input | 2 | Character register select |
| wr_data_i | input | 8 | Character written, parity in bit 7 |
| luma_o | output | 10 | Luma override level code |
| luma_vld_o | output | 1 | luma_o replaces the video luma |
| rdy_o | output | 2 | Per-service ready-for-data flags |

## Verification
Lines are driven with refreshed pairs, with stale pairs, and with pairs where only the first character was rewritten. Comparing these separates the null-substitution path from the stored-data path and from the renewal rule. The designated lines are tried under both line standards, on off-target lines, and with each enable dropped and then restored. This shows whether a wrong line number, a wrong standard or a skipped enable is the cause of a missing or extra burst. A write landing mid-burst separates the snapshot taken at arming from the live registers. Every burst is decoded from the output samples at half-bit centres, which separates ordering faults (run-in phase, start bits, bit order) from rate faults, and the burst length is checked against the accumulator formula.

// File: rtl/cc_enc_pkg.sv
package cc_enc_pkg;

  typedef enum logic [1:0] {
    CC_IDLE = 2'd0,
    CC_WAIT = 2'd1,
    CC_SEND = 2'd2
  } cc_state_e;

  localparam int CC_SVC_N        = 2;
  localparam int CC_CHAR_W       = 8;
  localparam int CC_ACC_W        = 16;
  localparam int CC_RUNIN_HALVES = 14;
  localparam int CC_HALVES       = 52;
  localparam int CC_HALF_W       = 6;
  localparam logic [CC_CHAR_W-1:0] CC_NULL_CHAR = 8'h80;

  // one accumulator step: {overflow, new phase}
  function automatic logic [CC_ACC_W:0] cc_acc_step(input logic [CC_ACC_W-1:0] acc,
                                                    input logic [CC_ACC_W-1:0] inc);
    return {1'b0, acc} + {1'b0, inc};
  endfunction

  // symbol carried by half-bit h of the burst
  function automatic logic cc_half_level(input logic [CC_HALF_W-1:0] h,
                                         input logic [CC_CHAR_W-1:0] c0,
                                         input logic [CC_CHAR_W-1:0] c1);
    logic [CC_HALF_W-1:0] rel;
    logic [4:0]           bit_no;
    logic [2:0]           pos;
    logic                 lvl;
    rel    = h - 6'd14;
    bit_no = rel[5:1];
    pos    = 3'd0;
    lvl    = 1'b0;
    if (h < 6'd14) begin
      lvl = ~h[0];
    end else if (bit_no < 5'd2) begin
      lvl = 1'b0;
    end else if (bit_no == 5'd2) begin
      lvl = 1'b1;
    end else if (bit_no < 5'd11) begin
      pos = 3'(bit_no - 5'd3);
      lvl = c0[pos];
    end else begin
      pos = 3'(bit_no - 5'd11);
      lvl = c1[pos];
    end
    return lvl;
  endfunction

endpackage

// File: rtl/cc_svc_store.sv
module cc_svc_store
  import cc_enc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_lo_i,
  input  logic                 wr_hi_i,
  input  logic [CC_CHAR_W-1:0] wr_data_i,
  input  logic                 take_i,
  input  logic                 busy_i,
  output logic [CC_CHAR_W-1:0] first_o,
  output logic [CC_CHAR_W-1:0] second_o,
  output logic                 fresh_o,
  output logic                 rdy_o
);
  logic [CC_CHAR_W-1:0] lo_q, hi_q;
  logic                 fresh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      fresh_q <= 1'b0;
    end else begin
      if (wr_lo_i) lo_q <= wr_data_i;
      if (wr_hi_i) hi_q <= wr_data_i;
      if (wr_hi_i)     fresh_q <= 1'b1;
      else if (take_i) fresh_q <= 1'b0;
    end
  end

  assign first_o  = fresh_q ? lo_q : CC_NULL_CHAR;
  assign second_o = fresh_q ? hi_q : CC_NULL_CHAR;
  assign fresh_o  = fresh_q;
  assign rdy_o    = ~fresh_q & ~busy_i;
endmodule

// File: rtl/cc_half_tick.sv
module cc_half_tick
  import cc_enc_pkg::*;
#(
  parameter int HALF_INC = 2444
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam logic [CC_ACC_W-1:0] INC_V = CC_ACC_W'(HALF_INC);

  logic [CC_ACC_W-1:0] acc_q;
  logic [CC_ACC_W:0]   step;

  assign step   = cc_acc_step(acc_q, INC_V);
  assign tick_o = run_i & step[CC_ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (run_i) acc_q <= step[CC_ACC_W-1:0];
    else            acc_q <= '0;
  end
endmodule

// File: rtl/cc_line_seq.sv
module cc_line_seq
  import cc_enc_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int LVL_W     = 10,
  parameter int START_DLY = 284,
  parameter int CAP_L525  = 21,
  parameter int EXT_L525  = 284,
  parameter int CAP_L625  = 21,
  parameter int EXT_L625  = 334,
  parameter int BLANK_LVL = 240,
  parameter int HIGH_LVL  = 560
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                hstart_i,
  input  logic [LINE_W-1:0]                   line_num_i,
  input  logic                                std625_i,
  input  logic                                en_cap_i,
  input  logic                                en_ext_i,
  input  logic                                tick_i,
  input  logic [CC_SVC_N-1:0][CC_CHAR_W-1:0]  first_i,
  input  logic [CC_SVC_N-1:0][CC_CHAR_W-1:0]  second_i,
  output logic                                arm_o,
  output logic [CC_SVC_N-1:0]                 take_o,
  output logic [CC_SVC_N-1:0]                 busy_o,
  output logic                                run_o,
  output logic                                done_o,
  output logic [LVL_W-1:0]                    luma_o,
  output logic                                vld_o
);
  localparam int DLY_W = (START_DLY > 1) ? $clog2(START_DLY) : 1;
  localparam logic [DLY_W-1:0]     DLY_LAST  = DLY_W'(START_DLY - 1);
  localparam logic [CC_HALF_W-1:0] HALF_LAST = CC_HALF_W'(CC_HALVES - 1);
  localparam logic [LVL_W-1:0]     LVL_HI    = LVL_W'(HIGH_LVL);
  localparam logic [LVL_W-1:0]     LVL_LO    = LVL_W'(BLANK_LVL);

  cc_state_e             st_q;
  logic [DLY_W-1:0]      dly_q;
  logic [CC_HALF_W-1:0]  half_q;
  logic                  svc_q;
  logic [CC_CHAR_W-1:0]  tx0_q, tx1_q;

  logic [LINE_W-1:0] cap_line, ext_line;
  logic              hit_cap, hit_ext, pick_ext;

  assign cap_line = std625_i ? LINE_W'(CAP_L625) : LINE_W'(CAP_L525);
  assign ext_line = std625_i ? LINE_W'(EXT_L625) : LINE_W'(EXT_L525);
  assign hit_cap  = en_cap_i & (line_num_i == cap_line);
  assign hit_ext  = en_ext_i & (line_num_i == ext_line);
  assign pick_ext = ~hit_cap;

  assign arm_o     = (st_q == CC_IDLE) & hstart_i & (hit_cap | hit_ext);
  assign take_o[0] = arm_o & ~pick_ext;
  assign take_o[1] = arm_o & pick_ext;
  assign busy_o[0] = (st_q != CC_IDLE) & ~svc_q;
  assign busy_o[1] = (st_q != CC_IDLE) & svc_q;
  assign run_o     = (st_q == CC_SEND);
  assign done_o    = run_o & tick_i & (half_q == HALF_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CC_IDLE;
      dly_q  <= '0;
      half_q <= '0;
      svc_q  <= 1'b0;
      tx0_q  <= '0;
      tx1_q  <= '0;
    end else begin
      unique case (st_q)
        CC_IDLE: if (arm_o) begin
          st_q  <= CC_WAIT;
          dly_q <= '0;
          svc_q <= pick_ext;
          tx0_q <= first_i[pick_ext];
          tx1_q <= second_i[pick_ext];
        end
        CC_WAIT: begin
          if (dly_q == DLY_LAST) begin
            st_q   <= CC_SEND;
            half_q <= '0;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        CC_SEND: if (tick_i) begin
          if (half_q == HALF_LAST) st_q <= CC_IDLE;
          else                     half_q <= half_q + 1'b1;
        end
        default: st_q <= CC_IDLE;
      endcase
    end
  end

  assign vld_o  = run_o;
  assign luma_o = !run_o ? '0 : (cc_half_level(half_q, tx0_q, tx1_q) ? LVL_HI : LVL_LO);
endmodule

// File: rtl/cc_line_encoder.sv
module cc_line_encoder
  import cc_enc_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int LVL_W     = 10,
  parameter int START_DLY = 284,
  parameter int HALF_INC  = 2444,
  parameter int CAP_L525  = 21,
  parameter int EXT_L525  = 284,
  parameter int CAP_L625  = 21,
  parameter int EXT_L625  = 334,
  parameter int BLANK_LVL = 240,
  parameter int HIGH_LVL  = 560
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hstart_i,
  input  logic [LINE_W-1:0]    line_num_i,
  input  logic                 std625_i,
  input  logic                 en_cap_i,
  input  logic                 en_ext_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_addr_i,
  input  logic [CC_CHAR_W-1:0] wr_data_i,
  output logic [LVL_W-1:0]     luma_o,
  output logic                 luma_vld_o,
  output logic [CC_SVC_N-1:0]  rdy_o
);
  logic                               ev_arm, ev_tick, ev_done, run;
  logic [CC_SVC_N-1:0]                take, busy, fresh;
  logic [CC_SVC_N-1:0][CC_CHAR_W-1:0] first_c, second_c;

  for (genvar s = 0; s < CC_SVC_N; s++) begin : g_svc
    logic sel;
    assign sel = wr_en_i & (wr_addr_i[1] == 1'(s));
    cc_svc_store u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo_i   (sel & ~wr_addr_i[0]),
      .wr_hi_i   (sel & wr_addr_i[0]),
      .wr_data_i (wr_data_i),
      .take_i    (take[s]),
      .busy_i    (busy[s]),
      .first_o   (first_c[s]),
      .second_o  (second_c[s]),
      .fresh_o   (fresh[s]),
      .rdy_o     (rdy_o[s])
    );
  end

  cc_half_tick #(.HALF_INC(HALF_INC)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_o (ev_tick)
  );

  cc_line_seq #(
    .LINE_W(LINE_W), .LVL_W(LVL_W), .START_DLY(START_DLY),
    .CAP_L525(CAP_L525), .EXT_L525(EXT_L525),
    .CAP_L625(CAP_L625), .EXT_L625(EXT_L625),
    .BLANK_LVL(BLANK_LVL), .HIGH_LVL(HIGH_LVL)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .hstart_i   (hstart_i),
    .line_num_i (line_num_i),
    .std625_i   (std625_i),
    .en_cap_i   (en_cap_i),
    .en_ext_i   (en_ext_i),
    .tick_i     (ev_tick),
    .first_i    (first_c),
    .second_i   (second_c),
    .arm_o      (ev_arm),
    .take_o     (take),
    .busy_o     (busy),
    .run_o      (run),
    .done_o     (ev_done),
    .luma_o     (luma_o),
    .vld_o      (luma_vld_o)
  );
endmodule

// File: rtl/cc_line_encoder_chk.sv
module cc_line_encoder_chk #(
  parameter int START_DLY = 284,
  parameter int LVL_W     = 10,
  parameter int HIGH_LVL  = 560
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic             en_cap_i,
  input logic             en_ext_i,
  input logic [LVL_W-1:0] luma_o,
  input logic             luma_vld_o,
  input logic [1:0]       rdy_o,
  input logic             ev_arm,
  input logic             ev_tick,
  input logic             ev_done
);
  logic [15:0] since_arm;

  always_ff @(posedge clk) begin
    if (!rst_n)                 since_arm <= 16'hFFFF;
    else if (ev_arm)            since_arm <= '0;
    else if (since_arm != '1)   since_arm <= since_arm + 1'b1;
  end

  // R4: burst starts a fixed delay after arming
  p_start_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(luma_vld_o) |-> since_arm == 16'(START_DLY));

  // R5: run-in opens on a high half
  p_runin_high_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(luma_vld_o) |-> luma_o == LVL_W'(HIGH_LVL));

  // R6: level only moves on a half-bit tick
  p_level_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (luma_vld_o && $past(luma_vld_o) && !$past(ev_tick)) |-> $stable(luma_o));

  // R6: burst closes right after the final tick
  p_end_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !luma_vld_o);

  // R7: nothing arms with both services off
  p_no_arm_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arm |-> (en_cap_i || en_ext_i));

  // R8: zero level outside a burst
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !luma_vld_o |-> luma_o == '0);

  // R9: second-character writes drop the ready flag
  p_cap_rdy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == 2'd1) |=> !rdy_o[0]);
  p_ext_rdy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == 2'd3) |=> !rdy_o[1]);
endmodule

bind cc_line_encoder cc_line_encoder_chk #(
  .START_DLY(START_DLY), .LVL_W(LVL_W), .HIGH_LVL(HIGH_LVL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .en_cap_i   (en_cap_i),
  .en_ext_i   (en_ext_i),
  .luma_o     (luma_o),
  .luma_vld_o (luma_vld_o),
  .rdy_o      (rdy_o),
  .ev_arm     (ev_arm),
  .ev_tick    (ev_tick),
  .ev_done    (ev_done)
);

// File: tb/tb_cc_line_encoder.sv
module tb_cc_line_encoder;
  localparam int CLK_P    = 10;
  localparam int DLY      = 284;
  localparam int INC      = 2444;
  localparam int LO       = 240;
  localparam int HI       = 560;
  localparam int LINE_CYC = 1800;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hstart_i = 1'b0;
  logic [9:0] line_num_i = '0;
  logic       std625_i = 1'b0;
  logic       en_cap_i = 1'b1;
  logic       en_ext_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [9:0] luma_o;
  logic       luma_vld_o;
  logic [1:0] rdy_o;

  cc_line_encoder dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int         m_state = 0;   // 0 idle, 1 delay, 2 burst
  int         m_wleft = 0;
  int         m_acc = 0;
  int         m_svc = 0;
  bit         m_q[$];
  logic [7:0] m_reg[4];
  bit         m_fresh[2];
  logic [7:0] m_b0, m_b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_q.delete(); m_fresh[0] = 0; m_fresh[1] = 0;
      foreach (m_reg[i]) m_reg[i] = 8'h00;
    end else begin
      if (m_state == 0) begin
        if (hstart_i) begin
          int s;
          s = -1;
          if (en_cap_i && line_num_i == 10'd21) s = 0;
          else if (en_ext_i && line_num_i == (std625_i ? 10'd334 : 10'd284)) s = 1;
          if (s >= 0) begin
            m_svc = s;
            m_b0 = m_fresh[s] ? m_reg[2*s] : 8'h80;
            m_b1 = m_fresh[s] ? m_reg[2*s+1] : 8'h80;
            m_fresh[s] = 0;
            m_q.delete();
            for (int i = 0; i < 7; i++) begin m_q.push_back(1); m_q.push_back(0); end
            m_q.push_back(0); m_q.push_back(0); m_q.push_back(0); m_q.push_back(0);
            m_q.push_back(1); m_q.push_back(1);
            for (int k = 0; k < 8; k++) begin m_q.push_back(m_b0[k]); m_q.push_back(m_b0[k]); end
            for (int k = 0; k < 8; k++) begin m_q.push_back(m_b1[k]); m_q.push_back(m_b1[k]); end
            m_wleft = DLY;
            m_state = 1;
          end
        end
      end else if (m_state == 1) begin
        m_wleft--;
        if (m_wleft == 0) begin m_state = 2; m_acc = 0; end
      end else begin
        m_acc += INC;
        if (m_acc >= 65536) begin
          m_acc -= 65536;
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_state = 0;
        end
      end
      if (wr_en_i) begin
        m_reg[wr_addr_i] = wr_data_i;
        if (wr_addr_i[0]) m_fresh[wr_addr_i[1]] = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int exp_l;
      exp_l = (m_state == 2) ? (m_q[0] ? HI : LO) : 0;
      check("R8 vld per cycle", int'(luma_vld_o), int'(m_state == 2));
      check("R5 luma per cycle", int'(luma_o), exp_l);
      for (int s = 0; s < 2; s++)
        check("R9 rdy per cycle", int'(rdy_o[s]),
              int'(!m_fresh[s] && !(m_state != 0 && m_svc == s)));
    end
  end

  // ---------------- burst capture ----------------
  int cap_q[$];
  int first_cyc = -1;
  always @(negedge clk) begin
    if (luma_vld_o) begin
      if (cap_q.size() == 0) first_cyc = cyc;
      cap_q.push_back(int'(luma_o));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  function automatic bit half_at(input int h);
    int j;
    j = (h * 65536 + 32768) / INC;
    if (j >= cap_q.size()) return 0;
    return cap_q[j] == HI;
  endfunction

  task automatic run_line(input int line, input bit std, input bit exp_tx,
                          input logic [7:0] e0, input logic [7:0] e1, input string tag,
                          input bit mid, input logic [7:0] mb0, input logic [7:0] mb1);
    int arm_cyc;
    int spent;
    logic [7:0] g0, g1;
    bit pat_ok;
    cap_q.delete(); first_cyc = -1;
    line_num_i = 10'(line); std625_i = std; hstart_i = 1'b1;
    arm_cyc = cyc + 1;
    @(negedge clk);
    hstart_i = 1'b0;
    spent = 1;
    if (mid) begin
      repeat (600) @(negedge clk);
      wr(2'd0, mb0); wr(2'd1, mb1);
      spent += 602;
    end
    repeat (LINE_CYC - spent) @(negedge clk);
    if (!exp_tx) begin
      check({tag, " no burst"}, cap_q.size(), 0);
    end else begin
      check("R4 start delay", first_cyc - arm_cyc, DLY);
      check("R6 burst length", cap_q.size(), (52 * 65536 + INC - 1) / INC);
      pat_ok = 1;
      for (int h = 0; h < 14; h++) if (half_at(h) != (h % 2 == 0)) pat_ok = 0;
      for (int h = 14; h < 18; h++) if (half_at(h)) pat_ok = 0;
      if (!half_at(18) || !half_at(19)) pat_ok = 0;
      check("R5 run-in and start", int'(pat_ok), 1);
      for (int k = 0; k < 8; k++) begin
        g0[k] = half_at(20 + 2 * k);
        g1[k] = half_at(36 + 2 * k);
      end
      check({tag, " first char"}, int'(g0), int'(e0));
      check({tag, " second char"}, int'(g1), int'(e1));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R9 reset rdy", int'(rdy_o), 3);
    check("R8 reset vld", int'(luma_vld_o), 0);
    check("R8 reset luma", int'(luma_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: first character alone does not renew
    wr(2'd0, 8'h41);
    check("R1 rdy after first-char write", int'(rdy_o[0]), 1);
    run_line(21, 0, 1, 8'h80, 8'h80, "R1", 0, 0, 0);

    // R2: renewed pair is sent as written
    wr(2'd0, 8'hC1); wr(2'd1, 8'hC2);
    check("R9 rdy low after second write", int'(rdy_o[0]), 0);
    run_line(21, 0, 1, 8'hC1, 8'hC2, "R2", 0, 0, 0);
    check("R9 rdy back after line", int'(rdy_o[0]), 1);
    run_line(21, 0, 1, 8'h80, 8'h80, "R2 null", 0, 0, 0);

    // R3: extended line per standard
    wr(2'd2, 8'h15); wr(2'd3, 8'hAE);
    run_line(284, 0, 1, 8'h15, 8'hAE, "R3 ext 525", 0, 0, 0);
    wr(2'd2, 8'h07); wr(2'd3, 8'h70);
    run_line(284, 1, 0, 0, 0, "R3 284 in 625", 0, 0, 0);
    check("R3 ext still pending", int'(rdy_o[1]), 0);
    run_line(334, 1, 1, 8'h07, 8'h70, "R3 ext 625", 0, 0, 0);
    run_line(22, 0, 0, 0, 0, "R3 off-target line", 0, 0, 0);

    // R7: disabled service keeps its pair
    en_cap_i = 1'b0;
    wr(2'd0, 8'h01); wr(2'd1, 8'h02);
    run_line(21, 0, 0, 0, 0, "R7 disabled", 0, 0, 0);
    check("R7 pair still pending", int'(rdy_o[0]), 0);
    en_cap_i = 1'b1;
    run_line(21, 0, 1, 8'h01, 8'h02, "R7 re-enabled", 0, 0, 0);

    // R10: mid-burst write waits for next line
    wr(2'd0, 8'h9D); wr(2'd1, 8'h3B);
    run_line(21, 0, 1, 8'h9D, 8'h3B, "R10 in flight", 1, 8'h5E, 8'hE5);
    check("R10 newer pair pending", int'(rdy_o[0]), 0);
    run_line(21, 1, 1, 8'h5E, 8'hE5, "R10 next line", 0, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule